// File: doc/BRIEF.md
# Multi-Lane Candidate Report Collector

The collector gathers results from a bank of parallel key-search lanes and presents them to a board controller. A lane raises its post request when it has either a candidate key or has run out of keys and needs a new starting point. It holds that request until the collector acknowledges it. The collector picks one posting lane at a time in rotating order and latches the report into a single-entry register set. The report holds the lane number, the strapped chip number and either the 64-bit key or an all-ones finish code. The collector then pulses an acknowledge back to that lane, so the lane resumes after a couple of cycles instead of sitting halted until it is interrogated.

The controller sees a level flag, reads the report through a small address/data port, and writes the status register to release the entry. While the entry is occupied, further posts wait with their requests held. They are served in turn once the flag is cleared.

Top module: `cand_collector`

## Requirements
- R1: After reset the flag `irq` is 0, every `lane_ack` bit is 0 and the status register (address 0) reads 0.
- R2: When the entry is empty and at least one lane holds `lane_req`, the report is captured on the next rising edge. From that edge `irq` is 1 and status bit 0 (full) reads 1.
- R3: Each capture produces a one-cycle pulse on exactly one `lane_ack` bit, the bit of the captured lane. No acknowledge occurs at any other time.
- R4: Address 1 reads the captured lane number in bits [15:0] and `chip_id`, zero-extended, in bits [31:16].
- R5: For a candidate post (`lane_fin` bit 0), status bit 1 reads 0. Address 2 reads key bits [31:0] and address 3 reads key bits [63:32] of that lane's `lane_key` slice, where lane i uses `lane_key[64*i+63:64*i]`.
- R6: For a finish post (`lane_fin` bit 1), status bit 1 reads 1 and addresses 2 and 3 both read 32'hFFFF_FFFF, whatever the lane's key input holds.
- R7: While the entry is full, nothing further is captured or acknowledged and the report contents stay unchanged, even when other lanes are posting.
- R8: A write to address 0 while the entry is full clears it: `irq` and status read 0 after that edge. Writes to addresses 1 to 3 have no effect on the flag or on the report.
- R9: Grants rotate. After lane k is captured, the next capture goes to the first requesting lane in the order k+1, k+2, ..., wrapping past the last lane. Before any capture, lane 0 comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | CHIP_ID_W | Strapped chip number |
| lane_req | input | NUM_LANES | Per-lane post request, held until acknowledged |
| lane_fin | input | NUM_LANES | Per-lane post type: 1 = run finished, 0 = candidate |
| lane_key | input | NUM_LANES*64 | Per-lane 64-bit candidate key, lane i in slice i |
| lane_ack | output | NUM_LANES | One-cycle acknowledge to the captured lane |
| irq | output | 1 | Report entry full |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe (write to address 0 clears the entry) |
| bus_rdata | output | 32 | Read data for `bus_addr` |

## Verification
The hardest case to reach from the ports is a deep queue of held requests whose service order depends on the rotation pointer left by earlier grants. Isolated posts always look correct under any arbiter. The stimulus therefore begins with every lane posting at once, which must drain in index order. It then runs many rounds in which random subsets of lanes join while others are still waiting, so grants wrap past the last lane from varied pointer positions. Each round also carries finish posts with non-trivial key inputs and dummy writes to the data addresses while the entry is full.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int KEY_W  = 64;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_IDS  = 2'd1,
    REG_KLO  = 2'd2,
    REG_KHI  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cc_rr_arb.sv
module cc_rr_arb #(
  parameter int N  = 64,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          valid,
  output logic [LW-1:0] win
);
  logic [LW-1:0] last_q, last_d;

  // search starts one past the last winner and wraps
  always_comb begin
    valid = 1'b0;
    win   = '0;
    for (int i = 0; i < N; i++) begin
      int t;
      t = int'(last_q) + 1 + i;
      if (t >= N) t = t - N;
      if (!valid && req[t]) begin
        valid = 1'b1;
        win   = LW'(t);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (take) last_d = win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= LW'(N-1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/cc_report_store.sv
module cc_report_store
  import cc_pkg::*;
#(
  parameter int LW = 6,
  parameter int CW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clear,
  input  logic [LW-1:0]    in_lane,
  input  logic [CW-1:0]    in_chip,
  input  logic             in_fin,
  input  logic [KEY_W-1:0] in_key,
  output logic             full,
  output logic             fin,
  output logic [LW-1:0]    lane,
  output logic [CW-1:0]    chip,
  output logic [KEY_W-1:0] key
);
  logic             full_q, full_d;
  logic             fin_q;
  logic [LW-1:0]    lane_q;
  logic [CW-1:0]    chip_q;
  logic [KEY_W-1:0] key_q;

  always_comb begin
    full_d = full_q;
    if (capture)    full_d = 1'b1;
    else if (clear) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  // payload registers, clock enable = capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_q  <= 1'b0;
      lane_q <= '0;
      chip_q <= '0;
      key_q  <= '0;
    end else if (capture) begin
      fin_q  <= in_fin;
      lane_q <= in_lane;
      chip_q <= in_chip;
      key_q  <= in_key;
    end
  end

  assign full = full_q;
  assign fin  = fin_q;
  assign lane = lane_q;
  assign chip = chip_q;
  assign key  = key_q;
endmodule

// File: rtl/cc_bus_read.sv
module cc_bus_read
  import cc_pkg::*;
#(
  parameter int LW = 6,
  parameter int CW = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              full,
  input  logic              fin,
  input  logic [LW-1:0]     lane,
  input  logic [CW-1:0]     chip,
  input  logic [KEY_W-1:0]  key,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    unique case (reg_sel_e'(addr))
      REG_STAT: rdata = {{(DATA_W-2){1'b0}}, fin & full, full};
      REG_IDS:  rdata = {16'(chip), 16'(lane)};
      REG_KLO:  rdata = key[DATA_W-1:0];
      REG_KHI:  rdata = key[KEY_W-1:DATA_W];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cand_collector.sv
module cand_collector
  import cc_pkg::*;
#(
  parameter int NUM_LANES = 64,
  parameter int CHIP_ID_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CHIP_ID_W-1:0]       chip_id,
  input  logic [NUM_LANES-1:0]       lane_req,
  input  logic [NUM_LANES-1:0]       lane_fin,
  input  logic [NUM_LANES*KEY_W-1:0] lane_key,
  output logic [NUM_LANES-1:0]       lane_ack,
  output logic                       irq,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  output logic [DATA_W-1:0]          bus_rdata
);
  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic                 arb_valid;
  logic [LANE_W-1:0]    arb_win;
  logic                 capture, clear;
  logic                 cap_fin;
  logic [KEY_W-1:0]     cap_key;
  logic                 rep_full, rep_fin;
  logic [LANE_W-1:0]    rep_lane;
  logic [CHIP_ID_W-1:0] rep_chip;
  logic [KEY_W-1:0]     rep_key;
  logic [NUM_LANES-1:0] ack_q, ack_d;

  cc_rr_arb #(.N(NUM_LANES), .LW(LANE_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (lane_req),
    .take  (capture),
    .valid (arb_valid),
    .win   (arb_win)
  );

  assign capture = arb_valid & ~rep_full;
  assign clear   = bus_wr & (bus_addr == REG_STAT) & rep_full;
  assign cap_fin = lane_fin[arb_win];
  assign cap_key = cap_fin ? {KEY_W{1'b1}} : lane_key[arb_win*KEY_W +: KEY_W];

  cc_report_store #(.LW(LANE_W), .CW(CHIP_ID_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .clear   (clear),
    .in_lane (arb_win),
    .in_chip (chip_id),
    .in_fin  (cap_fin),
    .in_key  (cap_key),
    .full    (rep_full),
    .fin     (rep_fin),
    .lane    (rep_lane),
    .chip    (rep_chip),
    .key     (rep_key)
  );

  cc_bus_read #(.LW(LANE_W), .CW(CHIP_ID_W)) u_rd (
    .addr  (bus_addr),
    .full  (rep_full),
    .fin   (rep_fin),
    .lane  (rep_lane),
    .chip  (rep_chip),
    .key   (rep_key),
    .rdata (bus_rdata)
  );

  always_comb begin
    ack_d = '0;
    if (capture) ack_d[arb_win] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_d;
  end

  assign lane_ack = ack_q;
  assign irq      = rep_full;
endmodule

// File: rtl/cc_checker.sv
module cc_checker
  import cc_pkg::*;
#(
  parameter int N = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      lane_req,
  input logic [N-1:0]      lane_ack,
  input logic              irq,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rep_fin,
  input logic [KEY_W-1:0]  rep_key
);
  p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_ack));

  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_ack) |=> (lane_ack == '0));

  p_ack_to_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_ack) |-> ((lane_ack & $past(lane_req)) != '0));

  p_ack_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_ack) |-> irq);

  p_flag_rise_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (|lane_ack));

  p_hold_while_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && bus_addr == REG_STAT)) |=> (irq && lane_ack == '0));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && bus_wr && bus_addr == REG_STAT) |=> !irq);

  p_finish_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && rep_fin) |-> (rep_key == {KEY_W{1'b1}}));
endmodule

bind cand_collector cc_checker #(.N(NUM_LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lane_req (lane_req),
  .lane_ack (lane_ack),
  .irq      (irq),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .rep_fin  (rep_fin),
  .rep_key  (rep_key)
);

// File: tb/cand_collector_test.sv
module cand_collector_test;
  localparam int NL = 8;
  localparam int CW = 8;
  localparam logic [CW-1:0] CHIP = 8'hA5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NL-1:0]    lane_req = '0;
  logic [NL-1:0]    lane_fin = '0;
  logic [NL*64-1:0] lane_key = '0;
  logic [NL-1:0]    lane_ack;
  logic             irq;
  logic [1:0]       bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic [31:0]      bus_rdata;

  int checks = 0;
  int errors = 0;
  int last_m = NL - 1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cand_collector #(.NUM_LANES(NL), .CHIP_ID_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .chip_id(CHIP),
    .lane_req(lane_req), .lane_fin(lane_fin), .lane_key(lane_key),
    .lane_ack(lane_ack), .irq(irq),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [NL-1:0] p, input int last);
    for (int i = 0; i < NL; i++) begin
      int t;
      t = (last + 1 + i) % NL;
      if (p[t]) return t;
    end
    return -1;
  endfunction

  task automatic post(input int l, input bit f, input logic [63:0] k);
    lane_req[l] = 1'b1;
    lane_fin[l] = f;
    lane_key[l*64 +: 64] = k;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // serve one capture: the new posts were placed before this call
  task automatic serve();
    int w;
    logic [31:0] d;
    logic [63:0] ek;
    bit ef;
    @(negedge clk);
    w = pick(lane_req, last_m);
    chk(irq == 1'b1, "R2 irq after post", 64'(irq), 64'd1);
    chk(lane_ack == NL'(1 << w), "R3/R9 ack to rotating winner", 64'(lane_ack), 64'(1 << w));
    ef = lane_fin[w];
    ek = ef ? '1 : lane_key[w*64 +: 64];
    lane_req[w] = 1'b0;
    last_m = w;
    rd(2'd0, d);
    chk(d == {30'd0, ef, 1'b1}, ef ? "R6 status type" : "R5 status type", 64'(d), 64'({ef, 1'b1}));
    chk(lane_ack == '0, "R3 ack single cycle", 64'(lane_ack), 64'd0);
    rd(2'd1, d);
    chk(d == {16'(CHIP), 16'(w)}, "R4 lane and chip id", 64'(d), 64'({16'(CHIP), 16'(w)}));
    rd(2'd2, d);
    chk(d == ek[31:0], ef ? "R6 key low all ones" : "R5 key low", 64'(d), 64'(ek[31:0]));
    rd(2'd3, d);
    chk(d == ek[63:32], ef ? "R6 key high all ones" : "R5 key high", 64'(d), 64'(ek[63:32]));
    // write to a data address must not disturb anything
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = 2'($urandom_range(1, 3));
    @(negedge clk);
    bus_wr = 1'b0;
    chk(irq == 1'b1 && lane_ack == '0, "R8/R7 data write ignored, no new grant", 64'({irq, lane_ack}), 64'({1'b1, NL'(0)}));
    bus_addr = 2'd1;
    #1;
    chk(bus_rdata == {16'(CHIP), 16'(w)}, "R7 report unchanged", 64'(bus_rdata), 64'({16'(CHIP), 16'(w)}));
    // clear
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = 2'd0;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    chk(irq == 1'b0 && bus_rdata == 32'd0, "R8 clear by status write", 64'({irq, bus_rdata}), 64'd0);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    #9;
    @(negedge clk);
    chk(irq == 1'b0 && lane_ack == '0, "R1 reset outputs", 64'({irq, lane_ack}), 64'd0);
    bus_addr = 2'd0;
    #1;
    chk(bus_rdata == 32'd0, "R1 reset status", 64'(bus_rdata), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0 && lane_ack == '0, "R1 idle without posts", 64'({irq, lane_ack}), 64'd0);

    // directed: all lanes at once, lane 3 finished with a non-trivial key
    for (int l = 0; l < NL; l++)
      post(l, l == 3, {32'hC0DE0000 + 32'(l), $urandom});
    for (int n = 0; n < NL; n++) serve();

    // directed: lanes 6 and 1 wait; after last=7 lane 1 first, then 6 (R9 wrap)
    post(6, 1'b0, 64'h0123_4567_89AB_CDEF);
    post(1, 1'b0, 64'hFEDC_BA98_7654_3210);
    serve();
    serve();

    // random rounds
    for (int r = 0; r < 300; r++) begin
      int cnt;
      cnt = 0;
      for (int l = 0; l < NL; l++) begin
        if (!lane_req[l] && ($urandom_range(0, 3) == 0)) begin
          post(l, $urandom_range(0, 4) == 0, {$urandom, $urandom});
          cnt++;
        end
      end
      if (lane_req == '0) begin
        int l;
        l = $urandom_range(0, NL - 1);
        post(l, 1'b0, {$urandom, $urandom});
      end
      serve();
    end

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule